// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is one comparator channel of a high-resolution event timer. A shared free-running 64-bit main counter is presented on `cnt_i`, and `cnt_inc_i` marks the cycles in which that counter has taken a new value. The channel compares the counter against its stored comparator. When the counter reaches the comparator, and both the channel enable and the global enable are set, it raises a one-cycle edge interrupt on `irq_o`.

A channel works either in one-shot mode or in periodic mode. In periodic mode the comparator moves itself forward by the stored period after each match. If the counter has already run past several periods, extra additions on the following cycles bring the comparator ahead again, and only one interrupt is raised for the whole catch-up. A 32-bit mode limits the comparator, the period and the "is after" test to the low half of the counter. In 32-bit one-shot mode the channel also interrupts once when the low half of the counter wraps, before the real match. A self-clearing set-value bit selects whether a comparator write in periodic mode also loads the comparator.

The register decode, the main counter and the interrupt routing belong to the surrounding timer. This channel only receives write strobes for its configuration word and for the two comparator halves, and it shows its state on readback ports.

Top module: `evt_cmp_channel`

## Requirements
- R1: After reset the comparator reads all ones, the period reads zero, the configuration reads zero, `irq_o` is low and the wrap flag is clear.
- R2: The configuration word holds only bit 2 (channel enable), bit 3 (periodic), bit 6 (set-value) and bit 8 (32-bit mode). Every other bit reads zero, whatever was written to it.
- R3: A write to the low comparator half loads the comparator's low half when the channel is one-shot or set-value is 1. In periodic mode the same write also loads the period's low half. In 64-bit mode, a write to the high half loads the comparator's high half when the channel is one-shot or set-value is 1, and otherwise loads the period's high half.
- R4: Set-value returns to 0 after any write to either comparator half.
- R5: A period written through a comparator write has its top bit cleared. That bit is bit 31 in 32-bit mode and bit 63 in 64-bit mode.
- R6: A configuration write with bit 8 set clears the upper halves of both the comparator and the period. While 32-bit mode is on, those upper halves stay zero and writes to the high half have no effect.
- R7: In one-shot mode an interrupt is raised on a counter update whose value equals the comparator. In 32-bit mode only the low halves are compared.
- R8: In periodic mode with a non-zero period, a counter update that leaves the comparator not ahead of the counter raises one interrupt. The comparator then grows by the period, one addition per cycle, until it is ahead again. No further interrupt is raised during that catch-up.
- R9: "Ahead" means the signed difference comparator minus counter is positive. The difference is 32 bits wide in 32-bit mode and 64 bits wide otherwise, so the comparison works across the wrap of the counter.
- R10: In 32-bit one-shot mode, a counter update whose low half is zero raises an interrupt if the channel has been armed since its last match or wrap. The channel is armed by a configuration write, a comparator write or a rising global enable, and a match or a wrap disarms it.
- R11: No interrupt is raised unless both the channel enable bit and `glb_en_i` are 1. With `glb_en_i` at 0, no match or wrap is evaluated.
- R12: `irq_o` is high for one cycle, in the cycle after a `cnt_inc_i` cycle that caused it, and never otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| cnt_i | input | 64 | Main counter value |
| cnt_inc_i | input | 1 | Main counter took a new value this cycle |
| glb_en_i | input | 1 | Global timer enable |
| cfg_we_i | input | 1 | Configuration word write strobe |
| cfg_wdata_i | input | 32 | Configuration write data |
| cmp_lo_we_i | input | 1 | Low comparator half write strobe |
| cmp_hi_we_i | input | 1 | High comparator half write strobe |
| cmp_wdata_i | input | 32 | Comparator write data |
| irq_o | output | 1 | Edge interrupt pulse |
| cfg_o | output | 32 | Configuration readback |
| cmp_o | output | 64 | Comparator readback |
| per_o | output | 64 | Period readback |

## Verification
The hardest situations to reach are those where the counter lies far from the comparator: a periodic channel that must catch up over several periods, the 32-bit signed test across the wrap, and the extra wrap interrupt. The counter is an input, so the bench sets it to any value without an update strobe and then jumps it several periods ahead, or to just below a 32-bit boundary, with one strobe. Upper counter bits are set to non-zero values to show that the 32-bit compare ignores them. Small periods and starting points are swept exhaustively, and the expected interrupt ticks are computed with modular arithmetic.

// File: rtl/evt_cmp_channel.sv
module evt_cmp_channel #(
  parameter int CW = 64
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] cnt_i,
  input  logic          cnt_inc_i,
  input  logic          glb_en_i,
  input  logic          cfg_we_i,
  input  logic [31:0]   cfg_wdata_i,
  input  logic          cmp_lo_we_i,
  input  logic          cmp_hi_we_i,
  input  logic [CW/2-1:0] cmp_wdata_i,
  output logic          irq_o,
  output logic [31:0]   cfg_o,
  output logic [CW-1:0] cmp_o,
  output logic [CW-1:0] per_o
);
  localparam int HW = CW / 2;
  localparam int B_EN = 2;
  localparam int B_PER = 3;
  localparam int B_SETV = 6;
  localparam int B_M32 = 8;

  logic [CW-1:0] cmp_q, per_q;
  logic en_q, per_mode_q, setv_q, m32_q;
  logic wrap_arm_q, chase_q, glb_q, irq_q;

  logic [CW-1:0] d_full;
  logic [HW-1:0] d_half;
  logic ahead, eq, any_we, stepping, step_now;
  logic match_os, match_per, wrap_hit, load_cmp;
  logic [CW-1:0] cmp_adv;
  logic [HW-1:0] wv_mask;

  assign d_full   = cmp_q - cnt_i;
  assign d_half   = cmp_q[HW-1:0] - cnt_i[HW-1:0];
  assign ahead    = m32_q ? ($signed(d_half) > 0) : ($signed(d_full) > 0);
  assign eq       = m32_q ? (cmp_q[HW-1:0] == cnt_i[HW-1:0]) : (cmp_q == cnt_i);
  assign any_we   = cfg_we_i | cmp_lo_we_i | cmp_hi_we_i;
  assign stepping = per_mode_q && (per_q != '0);

  assign step_now  = glb_en_i && stepping && !ahead && (cnt_inc_i || chase_q) && !any_we;
  assign match_per = glb_en_i && cnt_inc_i && stepping && !ahead && !chase_q;
  assign match_os  = glb_en_i && cnt_inc_i && !stepping && eq;
  assign wrap_hit  = glb_en_i && cnt_inc_i && m32_q && !per_mode_q && wrap_arm_q
                     && (cnt_i[HW-1:0] == '0);

  assign cmp_adv  = m32_q ? {{HW{1'b0}}, cmp_q[HW-1:0] + per_q[HW-1:0]} : cmp_q + per_q;
  assign load_cmp = !per_mode_q || setv_q;
  assign wv_mask  = {1'b0, cmp_wdata_i[HW-2:0]};

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cmp_q      <= '1;
      per_q      <= '0;
      en_q       <= 1'b0;
      per_mode_q <= 1'b0;
      setv_q     <= 1'b0;
      m32_q      <= 1'b0;
      wrap_arm_q <= 1'b0;
      chase_q    <= 1'b0;
      glb_q      <= 1'b0;
      irq_q      <= 1'b0;
    end else begin
      irq_q   <= (match_per || match_os || wrap_hit) && en_q;
      glb_q   <= glb_en_i;
      chase_q <= step_now;
      if (step_now) cmp_q <= cmp_adv;

      if (any_we || (glb_en_i && !glb_q)) wrap_arm_q <= 1'b1;
      else if (match_os || wrap_hit) wrap_arm_q <= 1'b0;

      if (cfg_we_i) begin
        en_q       <= cfg_wdata_i[B_EN];
        per_mode_q <= cfg_wdata_i[B_PER];
        setv_q     <= cfg_wdata_i[B_SETV];
        m32_q      <= cfg_wdata_i[B_M32];
        if (cfg_wdata_i[B_M32]) begin
          cmp_q <= {{HW{1'b0}}, cmp_q[HW-1:0]};
          per_q <= {{HW{1'b0}}, per_q[HW-1:0]};
        end
      end else if (cmp_lo_we_i) begin
        if (load_cmp) cmp_q[HW-1:0] <= cmp_wdata_i;
        if (per_mode_q) per_q[HW-1:0] <= m32_q ? wv_mask : cmp_wdata_i;
        setv_q <= 1'b0;
      end else if (cmp_hi_we_i) begin
        if (!m32_q) begin
          if (load_cmp) cmp_q[CW-1:HW] <= cmp_wdata_i;
          else per_q[CW-1:HW] <= wv_mask;
        end
        setv_q <= 1'b0;
      end
    end
  end

  always_comb begin
    cfg_o         = '0;
    cfg_o[B_EN]   = en_q;
    cfg_o[B_PER]  = per_mode_q;
    cfg_o[B_SETV] = setv_q;
    cfg_o[B_M32]  = m32_q;
  end

  assign irq_o = irq_q;
  assign cmp_o = cmp_q;
  assign per_o = per_q;
endmodule

// File: rtl/evt_cmp_channel_chk.sv
module evt_cmp_channel_chk #(
  parameter int CW = 64
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cnt_inc_i,
  input logic          glb_en_i,
  input logic          cfg_we_i,
  input logic          cmp_lo_we_i,
  input logic          cmp_hi_we_i,
  input logic          irq_o,
  input logic [31:0]   cfg_o,
  input logic [CW-1:0] cmp_o,
  input logic [CW-1:0] per_o
);
  localparam int HW = CW / 2;

  p_irq_after_inc_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(cnt_inc_i));

  p_irq_enabled_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ($past(glb_en_i) && $past(cfg_o[2])));

  p_setv_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmp_lo_we_i || cmp_hi_we_i) && !cfg_we_i) |=> !cfg_o[6]);

  p_upper_zero_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_o[8] |-> (cmp_o[CW-1:HW] == '0 && per_o[CW-1:HW] == '0));

  p_per_top_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !per_o[CW-1]);

  p_oneshot_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cfg_o[3] && !cfg_we_i && !cmp_lo_we_i && !cmp_hi_we_i) |=> $stable(cmp_o));

  p_cfg_fields_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_o & ~32'h0000_014C) == 32'h0);
endmodule

bind evt_cmp_channel evt_cmp_channel_chk #(.CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cnt_inc_i(cnt_inc_i), .glb_en_i(glb_en_i),
  .cfg_we_i(cfg_we_i), .cmp_lo_we_i(cmp_lo_we_i), .cmp_hi_we_i(cmp_hi_we_i),
  .irq_o(irq_o), .cfg_o(cfg_o), .cmp_o(cmp_o), .per_o(per_o)
);

// File: tb/evt_cmp_channel_tb_top.sv
`timescale 1ns/1ps
module evt_cmp_channel_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [63:0] cnt = '0;
  logic inc = 1'b0, glb = 1'b0;
  logic cfg_we = 1'b0, lo_we = 1'b0, hi_we = 1'b0;
  logic [31:0] cfg_wd = '0, cmp_wd = '0;
  logic irq;
  logic [31:0] cfg_rd;
  logic [63:0] cmp_rd, per_rd;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  evt_cmp_channel dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .cnt_inc_i(inc), .glb_en_i(glb),
    .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wd), .cmp_lo_we_i(lo_we), .cmp_hi_we_i(hi_we),
    .cmp_wdata_i(cmp_wd), .irq_o(irq), .cfg_o(cfg_rd), .cmp_o(cmp_rd), .per_o(per_rd)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input bit en, input bit per, input bit sv, input bit m32);
    @(negedge clk); cfg_we = 1'b1;
    cfg_wd = (32'(m32) << 8) | (32'(sv) << 6) | (32'(per) << 3) | (32'(en) << 2);
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic wr_lo(input logic [31:0] v);
    @(negedge clk); lo_we = 1'b1; cmp_wd = v;
    @(negedge clk); lo_we = 1'b0;
  endtask

  task automatic wr_hi(input logic [31:0] v);
    @(negedge clk); hi_we = 1'b1; cmp_wd = v;
    @(negedge clk); hi_we = 1'b0;
  endtask

  task automatic setcnt(input logic [63:0] v);
    @(negedge clk); cnt = v;
  endtask

  task automatic step(input logic [63:0] v, input bit exp, input string req);
    @(negedge clk); cnt = v; inc = 1'b1;
    @(posedge clk); #1 chk(irq === exp, req, 64'(irq), 64'(exp));
    @(negedge clk); inc = 1'b0;
    @(posedge clk); #1 chk(irq === 1'b0, "R12", 64'(irq), 64'h0);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    chk(cmp_rd === 64'hFFFF_FFFF_FFFF_FFFF, "R1", cmp_rd, 64'hFFFF_FFFF_FFFF_FFFF);
    chk(per_rd === 64'h0, "R1", per_rd, 64'h0);
    chk(cfg_rd === 32'h0, "R1", 64'(cfg_rd), 64'h0);
    chk(irq === 1'b0, "R1", 64'(irq), 64'h0);

    // R2: only the four fields are held
    @(negedge clk); cfg_we = 1'b1; cfg_wd = 32'hFFFF_FFFF;
    @(negedge clk); cfg_we = 1'b0;
    chk(cfg_rd === 32'h0000_014C, "R2", 64'(cfg_rd), 64'h14C);

    // R6: truncation and ignored high writes
    wr_cfg(1, 0, 0, 0);
    wr_hi(32'h1234); wr_lo(32'h5678);
    chk(cmp_rd === 64'h0000_1234_0000_5678, "R3", cmp_rd, 64'h0000_1234_0000_5678);
    wr_cfg(1, 0, 0, 1);
    chk(cmp_rd === 64'h5678, "R6", cmp_rd, 64'h5678);
    wr_hi(32'hABCD);
    chk(cmp_rd === 64'h5678, "R6", cmp_rd, 64'h5678);

    // R5: period top bit masking, both widths
    wr_cfg(1, 1, 0, 1);
    wr_lo(32'hFFFF_FFFF);
    chk(per_rd === 64'h7FFF_FFFF, "R5", per_rd, 64'h7FFF_FFFF);
    chk(cmp_rd === 64'h5678, "R3", cmp_rd, 64'h5678);
    wr_cfg(1, 1, 0, 0);
    wr_hi(32'hFFFF_FFFF);
    chk(per_rd[63:32] === 32'h7FFF_FFFF, "R5", per_rd, 64'h7FFF_FFFF_7FFF_FFFF);
    wr_hi(32'h0);
    wr_cfg(1, 1, 1, 0);
    chk(cfg_rd[6] === 1'b1, "R2", 64'(cfg_rd), 64'h4C);
    wr_hi(32'h0);
    chk(cfg_rd[6] === 1'b0, "R4", 64'(cfg_rd), 64'h0C);
    chk(cmp_rd === 64'h5678, "R3", cmp_rd, 64'h5678);

    // R7: one-shot sweep, 64-bit and 32-bit with upper counter bits
    for (int m = 0; m < 2; m++) begin
      for (int c = 1; c <= 6; c++) begin
        @(negedge clk); glb = 1'b0;
        setcnt({(m == 1) ? 32'h7 : 32'h0, 32'h0});
        wr_cfg(1, 0, 0, m[0]);
        wr_hi(32'h0); wr_lo(32'(c));
        @(negedge clk); glb = 1'b1;
        for (int t = 1; t <= 8; t++)
          step({(m == 1) ? 32'h7 : 32'h0, 32'(t)}, t == c, "R7");
      end
    end

    // R8: periodic sweep
    for (int p = 1; p <= 4; p++) begin
      for (int c = 1; c <= 4; c++) begin
        @(negedge clk); glb = 1'b0;
        setcnt(64'h0);
        wr_cfg(1, 1, 1, 0);
        wr_lo(32'(c)); wr_lo(32'(p));
        chk(cmp_rd === 64'(c), "R3", cmp_rd, 64'(c));
        chk(per_rd === 64'(p), "R3", per_rd, 64'(p));
        @(negedge clk); glb = 1'b1;
        for (int t = 1; t <= 14; t++)
          step(64'(t), (t >= c) && ((t - c) % p == 0), "R8");
      end
    end

    // R8: catch-up after a counter jump, single interrupt
    @(negedge clk); glb = 1'b0;
    setcnt(64'h0);
    wr_cfg(1, 1, 1, 0);
    wr_lo(32'd10); wr_lo(32'd3);
    @(negedge clk); glb = 1'b1;
    step(64'd20, 1'b1, "R8");
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1 chk(irq === 1'b0, "R8", 64'(irq), 64'h0);
    end
    chk(cmp_rd === 64'd22, "R8", cmp_rd, 64'd22);
    step(64'd21, 1'b0, "R8");
    step(64'd22, 1'b1, "R8");
    @(posedge clk); #1;
    chk(cmp_rd === 64'd25, "R8", cmp_rd, 64'd25);

    // R9: 32-bit periodic across the wrap, upper counter bits ignored
    @(negedge clk); glb = 1'b0;
    setcnt(64'h3_FFFF_FFFC);
    wr_cfg(1, 1, 1, 1);
    wr_lo(32'hFFFF_FFFE); wr_lo(32'd4);
    @(negedge clk); glb = 1'b1;
    step(64'h3_FFFF_FFFD, 1'b0, "R9");
    step(64'h3_FFFF_FFFE, 1'b1, "R9");
    chk(cmp_rd === 64'h2, "R9", cmp_rd, 64'h2);
    step(64'h4_0000_0000, 1'b0, "R9");
    step(64'h4_0000_0001, 1'b0, "R9");
    step(64'h4_0000_0002, 1'b1, "R9");

    // R9: 64-bit one-shot, equal low halves do not match
    @(negedge clk); glb = 1'b0;
    setcnt(64'h4_FFFF_FFFE);
    wr_cfg(1, 0, 0, 0);
    wr_hi(32'h5); wr_lo(32'h3);
    @(negedge clk); glb = 1'b1;
    step(64'h4_FFFF_FFFF, 1'b0, "R9");
    step(64'h5_0000_0000, 1'b0, "R10");
    step(64'h6_0000_0003, 1'b0, "R9");

    // R10: wrap interrupt in 32-bit one-shot, once per arming
    @(negedge clk); glb = 1'b0;
    setcnt(64'hFFFF_FFFE);
    wr_cfg(1, 0, 0, 1);
    wr_lo(32'd3);
    @(negedge clk); glb = 1'b1;
    step(64'h0_FFFF_FFFF, 1'b0, "R10");
    step(64'h1_0000_0000, 1'b1, "R10");
    step(64'h1_0000_0001, 1'b0, "R10");
    step(64'h1_0000_0002, 1'b0, "R10");
    step(64'h1_0000_0003, 1'b1, "R10");
    step(64'h1_FFFF_FFFF, 1'b0, "R10");
    step(64'h2_0000_0000, 1'b0, "R10");

    // R11: enables gate the interrupt
    @(negedge clk); glb = 1'b0;
    setcnt(64'h0);
    wr_cfg(0, 0, 0, 0);
    wr_hi(32'h0); wr_lo(32'd2);
    @(negedge clk); glb = 1'b1;
    for (int t = 1; t <= 3; t++) step(64'(t), 1'b0, "R11");
    @(negedge clk); glb = 1'b0;
    setcnt(64'h0);
    wr_cfg(1, 0, 0, 0);
    for (int t = 1; t <= 3; t++) step(64'(t), 1'b0, "R11");
    @(negedge clk); glb = 1'b1;
    setcnt(64'h0);
    step(64'd1, 1'b0, "R11");
    step(64'd2, 1'b1, "R11");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule